// File: doc/BRIEF.md
# Ethernet Transmit Stop Controller

This block sits between the transmit frame FIFO and the MAC transmit engine. It decides when the engine may start the next frame. Two control bits drive it: a global enable and a graceful-stop request. A graceful stop never cuts a frame short. The controller waits for the current frame to end, or for an early collision, then blocks further starts and raises a sticky stop-complete event. If no frame is on the wire when the request arrives, the event is raised at once. When the stop bit is cleared again, starts resume. A frame that was cut off by a collision during a stop is started again first.

Dropping the enable bit is the hard stop. In the same cycle it halts DMA and pulses the clears of both descriptor-active flags. It also orders the engine to close any frame in flight with a bad CRC, and holds that command until the engine reports that the frame has ended.

Top module: `tx_stop_ctrl`

## Requirements
- R1: After reset, the enable bit, the stop bit, the event bit and the mask bit all read 0. `dma_halt` is 1, and `start_permit` and `irq` are 0.
- R2: `start_permit` is high for exactly one cycle per frame. It goes high only when all of these hold: the block is idle, enable is 1, stop is 0, and either `fifo_frame_ready` is set or a retransmission is pending. No further start is issued until `eng_frame_done` is sampled.
- R3: A stop request made during a frame lets that frame end. The event bit reads 1 from the edge that samples `eng_frame_done`, and no start is issued while stopped.
- R4: A stop request written while enabled and idle sets the event bit at the edge that samples the write.
- R5: Writing stop=0 while stopped returns the block to idle at that edge. A start can follow in the next cycle.
- R6: An early collision while the stop bit is 1 stops at once, sets the event and records a pending retransmission. The first start after resume has `start_retx`=1, even if the FIFO is empty.
- R7: In the cycle a write clears enable, `dma_halt`, `clr_rdes_active` and `clr_xdes_active` are 1. If a frame is in flight and not ending, `abort_badcrc` is 1 from that cycle until `eng_frame_done`, and no start is issued meanwhile.
- R8: Clearing enable discards a pending retransmission.
- R9: No start is issued in a cycle in which a control write sets stop=1 or enable=0.
- R10: The event bit is sticky and is cleared by `evt_clr_wr` with `evt_clr_bit`=1; a completion in the same cycle wins. `irq` is event AND mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata_en | input | 1 | Enable bit value written |
| ctl_wdata_stop | input | 1 | Graceful-stop bit value written |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 1 | Mask bit value written |
| evt_clr_wr | input | 1 | Event write strobe (write-1-to-clear) |
| evt_clr_bit | input | 1 | Event bit value written |
| fifo_frame_ready | input | 1 | A whole frame waits in the transmit FIFO |
| eng_frame_done | input | 1 | Engine: current frame has ended |
| eng_early_col | input | 1 | Engine: early collision on current frame |
| ctl_enable | output | 1 | Enable bit readback |
| ctl_stop | output | 1 | Stop bit readback |
| start_permit | output | 1 | Permit the engine to start a frame |
| start_retx | output | 1 | The permitted start is a retransmission |
| abort_badcrc | output | 1 | End current frame with a bad CRC |
| dma_halt | output | 1 | Halt all DMA requests |
| clr_rdes_active | output | 1 | Clear receive descriptor-active flag |
| clr_xdes_active | output | 1 | Clear transmit descriptor-active flag |
| stop_event | output | 1 | Sticky stop-complete event |
| stop_mask | output | 1 | Event mask bit |
| irq | output | 1 | Masked event interrupt |

## Verification
A state register stuck in the sending states shows in the next cycle the FIFO is ready after a frame ends: `start_permit` stays low. A stop that is lost or reached too early shows as `stop_event` rising one edge away from the frame end or the request. A pending flag that survives a disable shows as an unexpected `start_retx` on the first start after re-enable. Since all handshake outputs are combinational from state and inputs, any divergence appears at the ports within one cycle of the stimulus that exposes it.

// File: rtl/tx_stop_pkg.sv
package tx_stop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SENDING  = 3'd1,
    ST_STOPPING = 3'd2,
    ST_STOPPED  = 3'd3,
    ST_ABORTING = 3'd4
  } tx_state_e;

  // Value a control bit takes in this cycle: a write in flight wins over the register.
  function automatic logic eff_bit(input logic wr, input logic wdata, input logic cur);
    return wr ? wdata : cur;
  endfunction

  function automatic logic frame_in_flight(input tx_state_e s);
    return (s == ST_SENDING) || (s == ST_STOPPING);
  endfunction

  // Sticky event update: set wins over write-1-to-clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/tx_stop_regs.sv
module tx_stop_regs
  import tx_stop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_wdata_en,
  input  logic ctl_wdata_stop,
  input  logic mask_wr,
  input  logic mask_wdata,
  input  logic evt_clr_wr,
  input  logic evt_clr_bit,
  input  logic stop_done,
  output logic en_q,
  output logic stop_q,
  output logic en_eff,
  output logic stop_eff,
  output logic en_fall,
  output logic mask_q,
  output logic evt_q,
  output logic irq
);

  logic evt_clr;

  assign en_eff   = eff_bit(ctl_wr, ctl_wdata_en, en_q);
  assign stop_eff = eff_bit(ctl_wr, ctl_wdata_stop, stop_q);
  assign en_fall  = ctl_wr & en_q & ~ctl_wdata_en;
  assign evt_clr  = evt_clr_wr & evt_clr_bit;
  assign irq      = evt_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      stop_q <= 1'b0;
      mask_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en_q   <= ctl_wdata_en;
        stop_q <= ctl_wdata_stop;
      end
      if (mask_wr) mask_q <= mask_wdata;
      evt_q <= sticky_next(evt_q, stop_done, evt_clr);
    end
  end

endmodule

// File: rtl/tx_stop_fsm.sv
module tx_stop_fsm
  import tx_stop_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_eff,
  input  logic      stop_eff,
  input  logic      en_fall,
  input  logic      fifo_ready,
  input  logic      retx_pending,
  input  logic      frame_done,
  input  logic      early_col,
  output logic      start_permit,
  output logic      abort_badcrc,
  output logic      stop_done,
  output logic      col_stop,
  output tx_state_e state_o
);

  tx_state_e state_q, state_d;
  logic      busy;

  assign busy    = frame_in_flight(state_q);
  assign state_o = state_q;

  assign start_permit = (state_q == ST_IDLE) & en_eff & ~stop_eff &
                        (fifo_ready | retx_pending);
  assign abort_badcrc = (state_q == ST_ABORTING) | (en_fall & busy & ~frame_done);

  always_comb begin
    state_d   = state_q;
    stop_done = 1'b0;
    col_stop  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (en_eff && stop_eff) begin
          state_d   = ST_STOPPED;
          stop_done = 1'b1;
        end else if (start_permit) begin
          state_d = ST_SENDING;
        end
      end
      ST_SENDING, ST_STOPPING: begin
        if (en_fall) begin
          state_d = frame_done ? ST_IDLE : ST_ABORTING;
        end else if (early_col && stop_eff) begin
          state_d   = ST_STOPPED;
          stop_done = 1'b1;
          col_stop  = 1'b1;
        end else if (frame_done) begin
          state_d   = stop_eff ? ST_STOPPED : ST_IDLE;
          stop_done = stop_eff;
        end else begin
          state_d = stop_eff ? ST_STOPPING : ST_SENDING;
        end
      end
      ST_STOPPED: begin
        if (!en_eff || !stop_eff) state_d = ST_IDLE;
      end
      ST_ABORTING: begin
        if (frame_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/tx_stop_retx.sv
module tx_stop_retx (
  input  logic clk,
  input  logic rst_n,
  input  logic col_stop,
  input  logic en_fall,
  input  logic start_permit,
  output logic pending,
  output logic start_retx
);

  assign start_retx = start_permit & pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pending <= 1'b0;
    else if (en_fall || start_permit) pending <= 1'b0;
    else if (col_stop)                pending <= 1'b1;
  end

endmodule

// File: rtl/tx_stop_ctrl.sv
module tx_stop_ctrl
  import tx_stop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_wdata_en,
  input  logic ctl_wdata_stop,
  input  logic mask_wr,
  input  logic mask_wdata,
  input  logic evt_clr_wr,
  input  logic evt_clr_bit,
  input  logic fifo_frame_ready,
  input  logic eng_frame_done,
  input  logic eng_early_col,
  output logic ctl_enable,
  output logic ctl_stop,
  output logic start_permit,
  output logic start_retx,
  output logic abort_badcrc,
  output logic dma_halt,
  output logic clr_rdes_active,
  output logic clr_xdes_active,
  output logic stop_event,
  output logic stop_mask,
  output logic irq
);

  // Named internal events, also seen by the bound checker.
  logic      en_eff, stop_eff, en_fall;
  logic      stop_done, col_stop, retx_pending;
  tx_state_e cur_state;

  tx_stop_regs regs_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_wr         (ctl_wr),
    .ctl_wdata_en   (ctl_wdata_en),
    .ctl_wdata_stop (ctl_wdata_stop),
    .mask_wr        (mask_wr),
    .mask_wdata     (mask_wdata),
    .evt_clr_wr     (evt_clr_wr),
    .evt_clr_bit    (evt_clr_bit),
    .stop_done      (stop_done),
    .en_q           (ctl_enable),
    .stop_q         (ctl_stop),
    .en_eff         (en_eff),
    .stop_eff       (stop_eff),
    .en_fall        (en_fall),
    .mask_q         (stop_mask),
    .evt_q          (stop_event),
    .irq            (irq)
  );

  tx_stop_fsm fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_eff       (en_eff),
    .stop_eff     (stop_eff),
    .en_fall      (en_fall),
    .fifo_ready   (fifo_frame_ready),
    .retx_pending (retx_pending),
    .frame_done   (eng_frame_done),
    .early_col    (eng_early_col),
    .start_permit (start_permit),
    .abort_badcrc (abort_badcrc),
    .stop_done    (stop_done),
    .col_stop     (col_stop),
    .state_o      (cur_state)
  );

  tx_stop_retx retx_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .col_stop     (col_stop),
    .en_fall      (en_fall),
    .start_permit (start_permit),
    .pending      (retx_pending),
    .start_retx   (start_retx)
  );

  assign dma_halt        = ~en_eff;
  assign clr_rdes_active = en_fall;
  assign clr_xdes_active = en_fall;

endmodule

// File: rtl/tx_stop_ctrl_chk.sv
module tx_stop_ctrl_chk
  import tx_stop_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      ctl_wr,
  input logic      ctl_wdata_en,
  input logic      ctl_wdata_stop,
  input logic      evt_clr_wr,
  input logic      eng_frame_done,
  input logic      ctl_enable,
  input logic      start_permit,
  input logic      start_retx,
  input logic      abort_badcrc,
  input logic      dma_halt,
  input logic      clr_rdes_active,
  input logic      clr_xdes_active,
  input logic      stop_event,
  input logic      stop_mask,
  input logic      irq,
  input tx_state_e cur_state
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!stop_event && !stop_mask && !ctl_enable));

  assert_one_start_per_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_permit |=> !start_permit);

  assert_stopped_blocks_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_STOPPED) |-> !start_permit);

  assert_idle_stop_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == ST_IDLE && ctl_wr && ctl_wdata_en && ctl_wdata_stop) |=> stop_event);

  assert_retx_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_retx |-> start_permit);

  assert_halt_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_enable && !ctl_wdata_en) |-> (dma_halt && clr_rdes_active && clr_xdes_active));

  assert_abort_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_badcrc && !eng_frame_done) |=> abort_badcrc);

  assert_no_start_in_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_permit, abort_badcrc}));

  assert_no_start_on_stop_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_permit |-> !(ctl_wr && (ctl_wdata_stop || !ctl_wdata_en)));

  assert_event_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_event && !evt_clr_wr) |=> stop_event);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stop_mask && stop_event));

endmodule

bind tx_stop_ctrl tx_stop_ctrl_chk chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .ctl_wr          (ctl_wr),
  .ctl_wdata_en    (ctl_wdata_en),
  .ctl_wdata_stop  (ctl_wdata_stop),
  .evt_clr_wr      (evt_clr_wr),
  .eng_frame_done  (eng_frame_done),
  .ctl_enable      (ctl_enable),
  .start_permit    (start_permit),
  .start_retx      (start_retx),
  .abort_badcrc    (abort_badcrc),
  .dma_halt        (dma_halt),
  .clr_rdes_active (clr_rdes_active),
  .clr_xdes_active (clr_xdes_active),
  .stop_event      (stop_event),
  .stop_mask       (stop_mask),
  .irq             (irq),
  .cur_state       (cur_state)
);

// File: tb/tx_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
module tx_stop_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_wdata_en = 0, ctl_wdata_stop = 0;
  logic mask_wr = 0, mask_wdata = 0, evt_clr_wr = 0, evt_clr_bit = 0;
  logic fifo_frame_ready = 0, eng_frame_done = 0, eng_early_col = 0;
  logic ctl_enable, ctl_stop, start_permit, start_retx, abort_badcrc, dma_halt;
  logic clr_rdes_active, clr_xdes_active, stop_event, stop_mask, irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model: 0 idle, 1 on wire, 2 on wire with stop asked, 3 stopped, 4 bad-CRC close
  int  m_st = 0;
  bit  m_en = 0, m_gts = 0, m_mask = 0, m_evt = 0, m_pend = 0;

  always #2.5 clk = ~clk;

  tx_stop_ctrl dut_i (.*);

  task automatic chk(string tag, string name, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
    end
  endtask

  function automatic bit want_start(bit en_e, bit gts_e);
    return (m_st == 0) && en_e && !gts_e && (fifo_frame_ready || m_pend);
  endfunction

  task automatic step(string tag, bit wr, bit wen, bit wst, bit mwr, bit mwd,
                      bit cw, bit cb, bit fr, bit fd, bit ec);
    bit en_e, gts_e, efall, on_wire, st, ab, done, cstop;
    int nx;
    @(negedge clk);
    ctl_wr = wr; ctl_wdata_en = wen; ctl_wdata_stop = wst;
    mask_wr = mwr; mask_wdata = mwd; evt_clr_wr = cw; evt_clr_bit = cb;
    fifo_frame_ready = fr; eng_frame_done = fd; eng_early_col = ec;
    #1;
    en_e    = wr ? wen : m_en;
    gts_e   = wr ? wst : m_gts;
    efall   = wr && m_en && !wen;
    on_wire = (m_st == 1) || (m_st == 2);
    st      = want_start(en_e, gts_e);
    ab      = (m_st == 4) || (efall && on_wire && !fd);
    chk(tag, "start_permit", start_permit, st);
    chk(tag, "start_retx", start_retx, st && m_pend);
    chk(tag, "abort_badcrc", abort_badcrc, ab);
    chk(tag, "dma_halt", dma_halt, !en_e);
    chk(tag, "clr_rdes_active", clr_rdes_active, efall);
    chk(tag, "clr_xdes_active", clr_xdes_active, efall);
    chk(tag, "stop_event", stop_event, m_evt);
    chk(tag, "irq", irq, m_evt && m_mask);
    chk(tag, "ctl_enable", ctl_enable, m_en);
    // next model state
    done = 0; cstop = 0; nx = m_st;
    if (m_st == 0) begin
      if (en_e && gts_e) begin nx = 3; done = 1; end
      else if (st) nx = 1;
    end else if (on_wire) begin
      if (efall) nx = fd ? 0 : 4;
      else if (ec && gts_e) begin nx = 3; done = 1; cstop = 1; end
      else if (fd) begin nx = gts_e ? 3 : 0; done = gts_e; end
      else nx = gts_e ? 2 : 1;
    end else if (m_st == 3) begin
      if (!en_e || !gts_e) nx = 0;
    end else if (fd) nx = 0;
    m_st = nx;
    if (efall || st) m_pend = 0; else if (cstop) m_pend = 1;
    m_evt = done ? 1'b1 : ((cw && cb) ? 1'b0 : m_evt);
    if (mwr) m_mask = mwd;
    if (wr) begin m_en = wen; m_gts = wst; end
  endtask

  task automatic idle_step(string tag, bit fr, bit fd, bit ec);
    step(tag, 0, 0, 0, 0, 0, 0, 0, fr, fd, ec);
  endtask

  task automatic ctl(string tag, bit wen, bit wst, bit fr, bit fd, bit ec);
    step(tag, 1, wen, wst, 0, 0, 0, 0, fr, fd, ec);
  endtask

  initial begin
    int unsigned seed;
    int unsigned r;
    seed = 32'h0000_5A17;
    r = $urandom(seed);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1", "ctl_stop", ctl_stop, 1'b0);
    chk("R1", "stop_mask", stop_mask, 1'b0);
    idle_step("R1", 1, 0, 0);
    // R2 start only when enabled and a frame waits
    ctl("R2", 1, 0, 0, 0, 0);
    idle_step("R2", 1, 0, 0);
    idle_step("R2", 1, 0, 0);
    // R3 stop during frame waits for frame end
    ctl("R3", 1, 1, 1, 0, 0);
    idle_step("R3", 1, 0, 0);
    idle_step("R3", 1, 1, 0);
    idle_step("R3", 1, 0, 0);
    // R10 mask, irq, write-1-to-clear
    step("R10", 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    idle_step("R10", 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    idle_step("R10", 0, 0, 0);
    // R5 resume
    ctl("R5", 1, 0, 1, 0, 0);
    idle_step("R5", 1, 0, 0);
    // R6 collision during stop, retransmit on resume with empty FIFO
    ctl("R6", 1, 1, 0, 0, 0);
    idle_step("R6", 0, 0, 1);
    idle_step("R6", 0, 0, 0);
    ctl("R6", 1, 0, 0, 0, 0);
    idle_step("R6", 0, 0, 0);
    idle_step("R6", 0, 1, 0);
    // R4 stop while idle
    ctl("R4", 1, 1, 0, 0, 0);
    idle_step("R4", 0, 0, 0);
    // R8 pending discarded by disable
    ctl("R8", 1, 0, 1, 0, 0);
    idle_step("R8", 1, 0, 0);
    ctl("R8", 1, 1, 0, 0, 1);
    ctl("R8", 0, 1, 0, 0, 0);
    ctl("R8", 1, 0, 0, 0, 0);
    idle_step("R8", 0, 0, 0);
    // R7 hard disable mid-frame
    idle_step("R7", 1, 0, 0);
    ctl("R7", 0, 0, 1, 0, 0);
    idle_step("R7", 1, 0, 0);
    idle_step("R7", 1, 1, 0);
    idle_step("R7", 1, 0, 0);
    // R9 no start in the write cycle
    ctl("R9", 1, 1, 1, 0, 0);
    ctl("R9", 1, 0, 1, 0, 0);
    idle_step("R9", 1, 0, 0);
    idle_step("R9", 1, 1, 0);
    ctl("R9", 0, 0, 1, 0, 0);
    ctl("R9", 1, 0, 1, 0, 0);
    // constrained random
    for (int i = 0; i < 6000; i++) begin
      bit wr, wen, wst;
      wr  = ($urandom % 100) < 6;
      wen = ($urandom % 100) < 80;
      wst = ($urandom % 100) < 40;
      step("RND", wr, wen, wst, ($urandom % 100) < 3, $urandom % 2,
           ($urandom % 100) < 5, $urandom % 2, ($urandom % 100) < 60,
           ($urandom % 100) < 15, ($urandom % 100) < 4);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule